// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This unit supplies memory addresses to a signal-processing datapath. It keeps a pointer register and presents an address on `addr_o` at all times. When the datapath makes an access it pulses `access_i`. The pointer then steps once, and the next address is on `addr_o` in the following cycle. No extra cycle and no extra instruction are spent on the address arithmetic.

There are three modes, chosen by `mode_i`:

- **Linear.** The pointer steps by one and wraps modulo the address space.
- **Circular.** The pointer stays inside a buffer bounded by a programmed first address and last address. Stepping past either bound wraps to the other bound in the same update.
- **Bit-reverse.** The pointer still steps linearly, but the output address has its low `rev_bits_i` bits mirrored. This produces the shuffled orderings that FFT stages need. The bit count is set per stage, and the upper bits pass through unchanged.

The pointer and both bounds are loaded through a small write port. Software or a sequencer loads the bounds once and then only strobes accesses.

Top module: `agu_modrev`

## Requirements
- R1: After reset the pointer, first-address and last-address registers are all zero, so `addr_o` reads 0.
- R2: A write with `wr_en_i`=1 loads `wr_data_i` into one register, chosen by `wr_sel_i`: 0 is the pointer, 1 is the first address, 2 is the last address. Code 3 changes nothing. A pointer write is visible on `addr_o` in the next cycle.
- R3: In linear mode (`mode_i`=0, and also code 3), an access adds 1 to the pointer when `dir_dec_i`=0 and subtracts 1 when `dir_dec_i`=1. The result wraps modulo 2^ADDR_W.
- R4: In circular mode (`mode_i`=1) with `dir_dec_i`=0, an access loads the first address if the pointer equals the last address. Otherwise it adds 1.
- R5: In circular mode with `dir_dec_i`=1, an access loads the last address if the pointer equals the first address. Otherwise it subtracts 1.
- R6: In bit-reverse mode (`mode_i`=2), output bit i equals pointer bit k-1-i for i<k, where k=`rev_bits_i`. Output bits at and above position k equal the pointer bits. For k=3 the low field maps 0→0, 1→4, 2→2, 3→6, 4→1, 5→5, 6→3, 7→7.
- R7: A reverse width of 0 in bit-reverse mode gives `addr_o` equal to the pointer. Outside bit-reverse mode `addr_o` equals the pointer whatever the value of `rev_bits_i`.
- R8: In bit-reverse mode the pointer itself steps linearly, as in R3. Starting from pointer 0 with k=3, successive accesses output 0,4,2,6,1,5,3,7.
- R9: Without an access and without a pointer write, the pointer holds. A pointer write in the same cycle as an access takes priority over the step.
- R10: When `access_i` is held high, a new address appears every cycle with no idle cycle at a buffer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 pointer, 1 first address, 2 last address |
| wr_data_i | input | ADDR_W | Write data |
| mode_i | input | 2 | 0 linear, 1 circular, 2 bit-reverse |
| dir_dec_i | input | 1 | 1 = step downward |
| rev_bits_i | input | REV_W | Number of low bits to reverse |
| access_i | input | 1 | Access strobe; steps the pointer at the clock edge |
| addr_o | output | ADDR_W | Current access address |

## Verification
`addr_o` is a combinational function of the pointer register, the mode and the reverse width. A change to the mode or to `rev_bits_i` therefore shows up in the same cycle. A write or an access moves the pointer at the next rising edge, so its effect is due one cycle later.

The bench drives inputs on the falling edge and samples `addr_o` on the next falling edge. That point is after exactly one register update, half a period away from any edge. For back-to-back accesses, `addr_o` is compared at every falling edge while the strobe stays high. This confirms that a buffer wrap costs no cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LINEAR = 2'd0,
    AGU_CIRC   = 2'd1,
    AGU_BITREV = 2'd2,
    AGU_RSVD   = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    SEL_PTR   = 2'd0,
    SEL_FIRST = 2'd1,
    SEL_LAST  = 2'd2,
    SEL_NONE  = 2'd3
  } agu_sel_e;
endpackage

// File: rtl/agu_regs.sv
module agu_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] ptr_nxt_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] last_o
);
  import agu_pkg::*;

  logic wr_ptr, wr_first, wr_last;

  assign wr_ptr   = wr_en_i && (wr_sel_i == SEL_PTR);
  assign wr_first = wr_en_i && (wr_sel_i == SEL_FIRST);
  assign wr_last  = wr_en_i && (wr_sel_i == SEL_LAST);

  // a pointer write wins over a step in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_o <= '0;
    else if (wr_ptr)   ptr_o <= wr_data_i;
    else if (step_i)   ptr_o <= ptr_nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        first_o <= '0;
    else if (wr_first)  first_o <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_o <= '0;
    else if (wr_last)  last_o <= wr_data_i;
  end
endmodule

// File: rtl/agu_ptr_next.sv
module agu_ptr_next #(
  parameter int ADDR_W = 16
) (
  input  agu_pkg::agu_mode_e mode_i,
  input  logic               dir_dec_i,
  input  logic [ADDR_W-1:0]  ptr_i,
  input  logic [ADDR_W-1:0]  first_i,
  input  logic [ADDR_W-1:0]  last_i,
  output logic [ADDR_W-1:0]  ptr_nxt_o
);
  import agu_pkg::*;

  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] inc, dec;
  logic              at_last, at_first;

  assign inc      = ptr_i + ONE;
  assign dec      = ptr_i - ONE;
  assign at_last  = (ptr_i == last_i);
  assign at_first = (ptr_i == first_i);

  always_comb begin
    ptr_nxt_o = dir_dec_i ? dec : inc;
    if (mode_i == AGU_CIRC) begin
      if (dir_dec_i) ptr_nxt_o = at_first ? last_i  : dec;
      else           ptr_nxt_o = at_last  ? first_i : inc;
    end
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int ADDR_W = 16,
  parameter int REV_W  = 4
) (
  input  logic              en_i,
  input  logic [REV_W-1:0]  width_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int MAX_K = (1 << REV_W) - 1;
  localparam int CAP_K = (MAX_K > ADDR_W) ? ADDR_W : MAX_K;

  int k;

  always_comb begin
    k = int'(width_i);
    if (k > CAP_K) k = CAP_K;
    if (!en_i) k = 0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < k) addr_o[i] = ptr_i[k-1-i];
      else       addr_o[i] = ptr_i[i];
    end
  end
endmodule

// File: rtl/agu_modrev.sv
module agu_modrev #(
  parameter int ADDR_W = 16,
  parameter int REV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [1:0]        mode_i,
  input  logic              dir_dec_i,
  input  logic [REV_W-1:0]  rev_bits_i,
  input  logic              access_i,
  output logic [ADDR_W-1:0] addr_o
);
  import agu_pkg::*;

  agu_mode_e         mode;
  logic [ADDR_W-1:0] ptr_q, first_q, last_q, ptr_nxt;

  assign mode = agu_mode_e'(mode_i);

  agu_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .step_i    (access_i),
    .ptr_nxt_i (ptr_nxt),
    .ptr_o     (ptr_q),
    .first_o   (first_q),
    .last_o    (last_q)
  );

  agu_ptr_next #(.ADDR_W(ADDR_W)) u_next (
    .mode_i    (mode),
    .dir_dec_i (dir_dec_i),
    .ptr_i     (ptr_q),
    .first_i   (first_q),
    .last_i    (last_q),
    .ptr_nxt_o (ptr_nxt)
  );

  agu_bitrev #(.ADDR_W(ADDR_W), .REV_W(REV_W)) u_rev (
    .en_i    (mode == AGU_BITREV),
    .width_i (rev_bits_i),
    .ptr_i   (ptr_q),
    .addr_o  (addr_o)
  );
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int ADDR_W = 16,
  parameter int REV_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [ADDR_W-1:0] wr_data_i,
  input logic [1:0]        mode_i,
  input logic              dir_dec_i,
  input logic [REV_W-1:0]  rev_bits_i,
  input logic              access_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [ADDR_W-1:0] first_q,
  input logic [ADDR_W-1:0] last_q
);
  logic wr_ptr, step, circ;

  assign wr_ptr = wr_en_i && (wr_sel_i == 2'd0);
  assign step   = access_i && !wr_ptr;
  assign circ   = (mode_i == 2'd1);

  // R2
  ptr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptr |=> ptr_q == $past(wr_data_i));

  // R4
  circ_up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && circ && !dir_dec_i && ptr_q == last_q |=> ptr_q == $past(first_q));

  // R4
  circ_up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && circ && !dir_dec_i && ptr_q != last_q |=> ptr_q == $past(ptr_q) + 1'b1);

  // R5
  circ_dn_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && circ && dir_dec_i && ptr_q == first_q |=> ptr_q == $past(last_q));

  // R9
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i && !wr_ptr |=> $stable(ptr_q));

  // R7
  rev_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd2 || rev_bits_i == '0) |-> addr_o == ptr_q);
endmodule

bind agu_modrev agu_chk #(.ADDR_W(ADDR_W), .REV_W(REV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .mode_i     (mode_i),
  .dir_dec_i  (dir_dec_i),
  .rev_bits_i (rev_bits_i),
  .access_i   (access_i),
  .addr_o     (addr_o),
  .ptr_q      (ptr_q),
  .first_q    (first_q),
  .last_q     (last_q)
);

// File: tb/sim_agu_modrev.sv
module sim_agu_modrev;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode = 2'd0;
  logic        dir_dec = 1'b0;
  logic [3:0]  rev_bits = '0;
  logic        access = 1'b0;
  logic [15:0] addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  agu_modrev u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .mode_i(mode), .dir_dec_i(dir_dec),
    .rev_bits_i(rev_bits), .access_i(access), .addr_o(addr)
  );

  function automatic logic [15:0] ref_rev(logic [15:0] p, int k);
    logic [15:0] low, mask, r;
    mask = (k == 0) ? 16'h0 : 16'((32'h1 << k) - 1);
    low  = p & mask;
    r = '0;
    for (int j = 0; j < k; j++) r = (r << 1) | ((low >> j) & 16'h1);
    return (p & ~mask) | r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    access = 1'b1;
    @(negedge clk);
    access = 1'b0;
  endtask

  initial begin
    logic [15:0] p, e;
    logic [15:0] seed;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset addr", addr, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr after release", addr, 16'h0000);

    // R2 pointer write
    wr(2'd0, 16'h1234);
    check("R2 ptr write", addr, 16'h1234);
    wr(2'd3, 16'hAAAA);
    check("R2 sel3 ignored", addr, 16'h1234);

    // R3 linear up/down and wrap
    wr(2'd0, 16'hFFFE);
    mode = 2'd0; dir_dec = 1'b0;
    p = 16'hFFFE;
    for (int i = 0; i < 4; i++) begin
      step(); p = p + 16'h1;
      check("R3 linear inc", addr, p);
    end
    dir_dec = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(); p = p - 16'h1;
      check("R3 linear dec", addr, p);
    end
    mode = 2'd3; dir_dec = 1'b0;
    step(); p = p + 16'h1;
    check("R3 code3 linear", addr, p);

    // R9 hold and write priority
    repeat (5) @(negedge clk);
    check("R9 hold", addr, p);
    @(negedge clk);
    access = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h0BEE;
    @(negedge clk);
    access = 1'b0; wr_en = 1'b0;
    check("R9 write beats step", addr, 16'h0BEE);

    // R4 circular up, strobe held (R10); sel3 write earlier left bounds at 0
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h0017);
    wr(2'd0, 16'h0014);
    mode = 2'd1; dir_dec = 1'b0;
    p = 16'h0014;
    @(negedge clk);
    access = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      p = (p == 16'h0017) ? 16'h0010 : p + 16'h1;
      check("R4 R10 circ inc", addr, p);
    end
    access = 1'b0;

    // R5 circular down
    dir_dec = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      p = (p == 16'h0010) ? 16'h0017 : p - 16'h1;
      check("R5 circ dec", addr, p);
    end

    // R5 degenerate one-entry buffer
    wr(2'd1, 16'h0040); wr(2'd2, 16'h0040); wr(2'd0, 16'h0040);
    step();
    check("R5 single entry dec", addr, 16'h0040);
    dir_dec = 1'b0;
    step();
    check("R4 single entry inc", addr, 16'h0040);

    // R6 R7 sweep of widths against computed reference
    mode = 2'd2;
    seed = 16'hACE1;
    for (int n = 0; n < 24; n++) begin
      seed = seed * 16'd25173 + 16'd13849;
      wr(2'd0, seed);
      for (int k = 0; k < 16; k++) begin
        rev_bits = 4'(k);
        #1;
        check((k == 0) ? "R7 width0 identity" : "R6 bitrev sweep", addr, ref_rev(seed, k));
      end
    end
    rev_bits = 4'd9; mode = 2'd1;
    #1;
    check("R7 no reverse in circ", addr, seed);

    // R6 fixed table for k=3 with upper bits set
    mode = 2'd2; rev_bits = 4'd3;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] tbl [8];
      tbl = '{3'd0, 3'd4, 3'd2, 3'd6, 3'd1, 3'd5, 3'd3, 3'd7};
      wr(2'd0, 16'hA5A0 | 16'(v));
      check("R6 k3 table", addr, 16'hA5A0 | 16'(tbl[v]));
    end

    // R8 R10 linear pointer under reversal, back-to-back
    wr(2'd0, 16'h0000);
    dir_dec = 1'b0;
    @(negedge clk);
    access = 1'b1;
    for (int i = 0; i < 8; i++) begin
      e = ref_rev(16'(i), 3);
      check("R8 R10 bitrev order", addr, e);
      @(negedge clk);
    end
    access = 1'b0;
    mode = 2'd0;
    #1;
    check("R8 pointer linear", addr, 16'h0008);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule